// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO

A first-in first-out buffer of 256 words of 18 bits. The write port and the read port each run on their own clock. Word counts cross between the two domains as Gray-coded pointers through two-flop synchronizers. Each flag is computed in the domain that acts on it, so it is always conservative for that side.

The read side has two timing modes, chosen once after reset. In standard mode every word, the first one included, is moved to the output only by a read. In fall-through mode the oldest word is placed on the output without a request, and a read consumes the word being shown. The shared empty pin then means "no word presented" instead of "memory empty".

Two more flags have programmable thresholds: almost-empty and almost-full. A half-full flag is also provided. The two threshold registers are written through the write port while a load strobe is held. A two-step sequencer takes one word per write and steps through the thresholds in a fixed order.

Top module: `dual_mode_fifo`

## Requirements
- R1: Words leave the read port in the order they were accepted at the write port, all 18 bits intact. The memory holds 256 words.
- R2: In standard mode (mode_i = 0), `rdata_o` changes only at a read-clock edge where `ren_i` is high and the memory holds a word. `empty_or_o` is high exactly when no unread word is in memory. Writing into an empty FIFO leaves `rdata_o` unchanged until a read.
- R3: In fall-through mode (mode_i = 1), a word written into an empty FIFO is on `rdata_o`, and `empty_or_o` falls, at the third rising read-clock edge after the write edge. No `ren_i` is needed. After the second such edge `empty_or_o` is still high.
- R4: In fall-through mode, a presented word stays on `rdata_o` until `ren_i` is high at a read-clock edge. That edge consumes it and shows the next word, or raises `empty_or_o` if no word is left.
- R5: `full_o` is high when 256 words are in memory. A write while full is dropped: it does not move the write pointer and does not corrupt stored data.
- R6: A read while no word is available is ignored. The read pointer and `rdata_o` stay unchanged, except for the first-word prefetch of fall-through mode.
- R7: `ae_o` is high when the number of available words is at most the almost-empty threshold. In fall-through mode the presented word is counted as available.
- R8: `af_o` is high when the memory word count is at least 256 minus the almost-full threshold.
- R9: `half_o` is high when more than 128 words are in memory.
- R10: After reset both pointers are cleared and both thresholds are 7. `empty_or_o` = 1, `full_o` = 0, `ae_o` = 1, `af_o` = 0 and `half_o` = 0.
- R11: A write-clock edge with both `load_i` and `wen_i` high stores `wdata_i[7:0]` into a threshold register instead of the FIFO. The almost-empty threshold is written first, then the almost-full threshold, then the order wraps.
- R12: `mode_i` is captured at the first read-clock edge after reset is released. Later changes to `mode_i` have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-domain clock |
| rclk_i | input | 1 | Read-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| mode_i | input | 1 | Read timing: 0 standard, 1 fall-through |
| wen_i | input | 1 | Write enable |
| load_i | input | 1 | Redirect writes to the threshold registers |
| wdata_i | input | 18 | Write data |
| ren_i | input | 1 | Read enable |
| rdata_o | output | 18 | Read data |
| empty_or_o | output | 1 | Empty (standard) / no word presented (fall-through) |
| full_o | output | 1 | Memory full; input not ready |
| ae_o | output | 1 | Almost-empty |
| af_o | output | 1 | Almost-full |
| half_o | output | 1 | More than half full |

## Verification
The assertions check on every cycle that:
- the word count never exceeds the depth;
- blocked writes, load writes and empty reads leave the pointers alone;
- the standard-mode output holds without a read, and a presented fall-through word holds without a read;
- the mode is locked after capture;
- a threshold load lands in the register that is due.

Only the bench scenarios can show the end-to-end behaviour: data order across both clock domains, the exact three-edge fall-through latency, the flag thresholds at their boundary counts, and the effect of reloaded thresholds.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
  typedef enum logic {RD_STD = 1'b0, RD_FWFT = 1'b1} rd_mode_e;
  typedef enum logic {OFS_AE = 1'b0, OFS_AF = 1'b1} ofs_sel_e;
endpackage

// File: rtl/dmf_sync2.sv
module dmf_sync2 #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dmf_mem.sv
module dmf_mem #(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 8
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dmf_wr_ctl.sv
module dmf_wr_ctl
  import dfifo_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned AE_DEF = 7,
  parameter int unsigned AF_DEF = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wen_i,
  input  logic          load_i,
  input  logic [AW-1:0] ofs_data_i,
  input  logic [AW:0]   rgray_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic [AW-1:0] ae_off_o,
  output logic          full_o,
  output logic          af_o,
  output logic          half_o
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  logic [PW-1:0] wbin_q, wgray_q, wbin_nx, rbin, count;
  logic [AW-1:0] ae_q, af_q;
  ofs_sel_e      sel_q;
  logic          push, ld_wr;

  always_comb begin
    rbin[PW-1] = rgray_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_i[i];
  end

  assign count   = wbin_q - rbin;
  assign full_o  = (count == DEPTH_P);
  assign af_o    = (count >= (DEPTH_P - {1'b0, af_q}));
  assign half_o  = (count > HALF_P);
  assign ld_wr   = wen_i && load_i;
  assign push    = wen_i && !load_i && !full_o;
  assign wbin_nx = wbin_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (push) begin
      wbin_q  <= wbin_nx;
      wgray_q <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  // threshold sequencer: almost-empty first, then almost-full, wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_q  <= AW'(AE_DEF);
      af_q  <= AW'(AF_DEF);
      sel_q <= OFS_AE;
    end else if (ld_wr) begin
      if (sel_q == OFS_AE) begin
        ae_q  <= ofs_data_i;
        sel_q <= OFS_AF;
      end else begin
        af_q  <= ofs_data_i;
        sel_q <= OFS_AE;
      end
    end
  end

  assign we_o     = push;
  assign waddr_o  = wbin_q[AW-1:0];
  assign wgray_o  = wgray_q;
  assign ae_off_o = ae_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= DEPTH_P); // R5
  AST_FULL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wen_i) |=> $stable(wbin_q)); // R5
  AST_LOAD_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> $stable(wbin_q)); // R11
  AST_LOAD_AE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_wr && sel_q == OFS_AE) |=> (ae_off_o == $past(ofs_data_i))); // R11
  AST_FLAG_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> (af_o && half_o)); // R8
endmodule

// File: rtl/dmf_rd_ctl.sv
module dmf_rd_ctl
  import dfifo_pkg::*;
#(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          ren_i,
  input  logic [AW:0]   wgray_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] rdata_o,
  output logic          empty_or_o,
  output logic          ae_o
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic          armed_q, ov_q, fwft, mem_empty, pop;
  rd_mode_e      mode_q;
  logic [PW-1:0] rbin_q, rgray_q, rbin_nx, wbin, count, avail;
  logic [DW-1:0] rdata_q;

  always_comb begin
    wbin[PW-1] = wgray_i[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_i[i];
  end

  // mode is latched once, on the first edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      mode_q  <= RD_STD;
    end else if (armed_q) begin
      armed_q <= 1'b0;
      mode_q  <= rd_mode_e'(mode_i);
    end
  end

  assign fwft      = (mode_q == RD_FWFT);
  assign mem_empty = (rgray_q == wgray_i);
  assign pop       = !armed_q && !mem_empty && (fwft ? (!ov_q || ren_i) : ren_i);
  assign rbin_nx   = rbin_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (pop) begin
      rbin_q  <= rbin_nx;
      rgray_q <= rbin_nx ^ (rbin_nx >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (pop) rdata_q <= mem_rdata_i;
  end

  // fall-through: output register holds a valid word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ov_q <= 1'b0;
    else if (pop && fwft)     ov_q <= 1'b1;
    else if (ren_i)           ov_q <= 1'b0;
  end

  assign count      = wbin - rbin_q;
  assign avail      = count + {{(PW-1){1'b0}}, fwft && ov_q};
  assign ae_o       = (avail <= {1'b0, ae_off_i});
  assign empty_or_o = fwft ? !ov_q : mem_empty;
  assign rdata_o    = rdata_q;
  assign raddr_o    = rbin_q[AW-1:0];
  assign rgray_o    = rgray_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= PW'(DEPTH)); // R1
  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_empty && ren_i) |=> $stable(rbin_q)); // R6
  AST_STD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !fwft && !ren_i) |=> $stable(rdata_o)); // R2
  AST_FWFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft && !empty_or_o && !ren_i) |=> (!empty_or_o && $stable(rdata_o))); // R4
  AST_MODE_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> $stable(mode_q)); // R12
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo #(
  parameter int unsigned DW     = 18,
  parameter int unsigned AW     = 8,
  parameter int unsigned AE_DEF = 7,
  parameter int unsigned AF_DEF = 7
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          wen_i,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ren_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_or_o,
  output logic          full_o,
  output logic          ae_o,
  output logic          af_o,
  output logic          half_o
);
  localparam int unsigned PW = AW + 1;

  logic          we;
  logic [AW-1:0] waddr, raddr, ae_off;
  logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;
  logic [DW-1:0] mem_rdata;

  dmf_wr_ctl #(.AW(AW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_wr (
    .clk_i      (wclk_i),
    .rst_ni     (rst_ni),
    .wen_i      (wen_i),
    .load_i     (load_i),
    .ofs_data_i (wdata_i[AW-1:0]),
    .rgray_i    (rgray_ws),
    .we_o       (we),
    .waddr_o    (waddr),
    .wgray_o    (wgray),
    .ae_off_o   (ae_off),
    .full_o     (full_o),
    .af_o       (af_o),
    .half_o     (half_o)
  );

  dmf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i  (wclk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  dmf_sync2 #(.W(PW)) u_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wgray),
    .q_o   (wgray_rs)
  );

  dmf_sync2 #(.W(PW)) u_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rgray),
    .q_o   (rgray_ws)
  );

  dmf_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
    .clk_i       (rclk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .ren_i       (ren_i),
    .wgray_i     (wgray_rs),
    .ae_off_i    (ae_off),
    .mem_rdata_i (mem_rdata),
    .raddr_o     (raddr),
    .rgray_o     (rgray),
    .rdata_o     (rdata_o),
    .empty_or_o  (empty_or_o),
    .ae_o        (ae_o)
  );
endmodule

// File: tb/dual_mode_fifo_test.sv
module dual_mode_fifo_test;
  logic        wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b0;
  logic        mode_i = 1'b0, wen_i = 1'b0, load_i = 1'b0, ren_i = 1'b0;
  logic [17:0] wdata_i = '0;
  logic [17:0] rdata_o;
  logic        empty_or_o, full_o, ae_o, af_o, half_o;

  int          n_chk = 0, n_fail = 0;
  bit          fwft_mode = 1'b0;
  logic [17:0] q [$];

  dual_mode_fifo uut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni), .mode_i(mode_i),
    .wen_i(wen_i), .load_i(load_i), .wdata_i(wdata_i), .ren_i(ren_i),
    .rdata_o(rdata_o), .empty_or_o(empty_or_o), .full_o(full_o),
    .ae_o(ae_o), .af_o(af_o), .half_o(half_o)
  );

  always #5 wclk = ~wclk;
  initial begin #3; forever #5 rclk = ~rclk; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: compares every consumed word against the scoreboard queue
  initial begin
    logic [17:0] got;
    forever begin
      @(posedge rclk);
      if (ren_i && !empty_or_o) begin
        if (fwft_mode) got = rdata_o;
        else begin #2; got = rdata_o; end
        if (q.size() == 0) chk("R1 unexpected word", 32'(got), 32'hFFFFFFFF);
        else chk("R1 order", 32'(got), 32'(q.pop_front()));
      end
    end
  end

  task automatic wr_burst(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wen_i   = 1'b1;
      wdata_i = 18'((seed + i) * 613 + 11);
      if (q.size() < 256) q.push_back(wdata_i);
    end
    @(negedge wclk);
    wen_i = 1'b0;
  endtask

  task automatic rd_n(input int n);
    @(negedge rclk);
    ren_i = 1'b1;
    repeat (n) @(negedge rclk);
    ren_i = 1'b0;
  endtask

  task automatic ld(input logic [17:0] v);
    @(negedge wclk);
    load_i = 1'b1; wen_i = 1'b1; wdata_i = v;
    @(negedge wclk);
    load_i = 1'b0; wen_i = 1'b0;
  endtask

  task automatic rsettle(); repeat (6) @(negedge rclk); endtask
  task automatic wsettle(); repeat (6) @(negedge wclk); endtask

  initial begin
    #1_800_000;
    chk("watchdog", 32'd1, 32'd0);
    summary();
  end

  initial begin
    logic [17:0] d;
    // ---------------- standard mode ----------------
    #27 rst_ni = 1'b1;
    rsettle();
    chk("R10 empty", 32'(empty_or_o), 32'd1);
    chk("R10 full", 32'(full_o), 32'd0);
    chk("R10 ae", 32'(ae_o), 32'd1);
    chk("R10 af", 32'(af_o), 32'd0);
    chk("R10 half", 32'(half_o), 32'd0);

    rd_n(2); rsettle();
    chk("R6 rdata after empty read", 32'(rdata_o), 32'd0);
    chk("R6 still empty", 32'(empty_or_o), 32'd1);

    d = 18'h1A5A5;
    @(negedge wclk); wen_i = 1'b1; wdata_i = d; q.push_back(d);
    @(negedge wclk); wen_i = 1'b0;
    rsettle();
    chk("R2 not empty", 32'(empty_or_o), 32'd0);
    chk("R2 no read no data", 32'(rdata_o), 32'd0);
    rd_n(1); rsettle();
    chk("R2 read moves word", 32'(rdata_o), 32'(d));
    chk("R2 empty again", 32'(empty_or_o), 32'd1);

    wr_burst(7, 100); rsettle();
    chk("R7 ae at 7", 32'(ae_o), 32'd1);
    wr_burst(1, 107); rsettle();
    chk("R7 ae at 8", 32'(ae_o), 32'd0);
    rd_n(8); rsettle();

    wr_burst(128, 200); wsettle();
    chk("R9 half at 128", 32'(half_o), 32'd0);
    wr_burst(1, 328); wsettle();
    chk("R9 half at 129", 32'(half_o), 32'd1);
    wr_burst(119, 329); wsettle();
    chk("R8 af at 248", 32'(af_o), 32'd0);
    wr_burst(1, 448); wsettle();
    chk("R8 af at 249", 32'(af_o), 32'd1);
    wr_burst(6, 449); wsettle();
    chk("R5 full at 255", 32'(full_o), 32'd0);
    wr_burst(1, 455); wsettle();
    chk("R5 full at 256", 32'(full_o), 32'd1);
    wr_burst(2, 900); wsettle();
    chk("R5 still full", 32'(full_o), 32'd1);
    rd_n(257); rsettle();
    chk("R5 drained, no extra word", 32'(q.size()), 32'd0);
    chk("R5 empty after drain", 32'(empty_or_o), 32'd1);

    // threshold load: ae=20, af=30, then wrap ae=5
    ld(18'd20); ld(18'd30); ld(18'd5); rsettle();
    chk("R11 load writes no data", 32'(empty_or_o), 32'd1);
    wr_burst(5, 1000); rsettle();
    chk("R11 ae threshold 5 at 5", 32'(ae_o), 32'd1);
    wr_burst(1, 1005); rsettle();
    chk("R11 ae threshold 5 at 6", 32'(ae_o), 32'd0);
    wr_burst(219, 1006); wsettle();
    chk("R11 af threshold 30 at 225", 32'(af_o), 32'd0);
    wr_burst(1, 1225); wsettle();
    chk("R11 af threshold 30 at 226", 32'(af_o), 32'd1);
    rd_n(226); rsettle();
    chk("R1 all words consumed", 32'(q.size()), 32'd0);

    // ---------------- fall-through mode ----------------
    @(negedge wclk); rst_ni = 1'b0; mode_i = 1'b1;
    repeat (3) @(negedge wclk);
    rst_ni = 1'b1;
    fwft_mode = 1'b1;
    q.delete();
    repeat (3) @(negedge rclk);
    mode_i = 1'b0; // must be ignored
    rsettle();
    chk("R10 fwft empty", 32'(empty_or_o), 32'd1);
    chk("R10 fwft ae", 32'(ae_o), 32'd1);

    rd_n(1); rsettle();
    chk("R6 fwft empty read", 32'(empty_or_o), 32'd1);

    d = 18'h2C3D4;
    @(negedge wclk); wen_i = 1'b1; wdata_i = d; q.push_back(d);
    @(posedge wclk); #1 wen_i = 1'b0;
    @(posedge rclk);
    @(posedge rclk); #2;
    chk("R3 empty after 2 edges", 32'(empty_or_o), 32'd1);
    @(posedge rclk); #2;
    chk("R3 ready after 3 edges", 32'(empty_or_o), 32'd0);
    chk("R3 word presented", 32'(rdata_o), 32'(d));
    chk("R12 mode held fall-through", 32'(rdata_o), 32'(d));

    wr_burst(3, 2000); rsettle();
    chk("R4 presented word held", 32'(rdata_o), 32'(d));
    rd_n(4); rsettle();
    chk("R4 empty after consume", 32'(empty_or_o), 32'd1);

    wr_burst(7, 3000); rsettle();
    chk("R7 fwft ae at 7", 32'(ae_o), 32'd1);
    wr_burst(1, 3007); rsettle();
    chk("R7 fwft ae at 8", 32'(ae_o), 32'd0);
    rd_n(8); rsettle();
    chk("R1 fwft all consumed", 32'(q.size()), 32'd0);

    summary();
  end
endmodule